// File: doc/BRIEF.md
# Comparator Output Digital Filter

This block takes the single-bit output of an analog comparator, which may chatter when its two inputs sit close together, and produces a clean, clock-synchronous version of it. The raw bit always passes through a two-flop synchronizer. When filtering is active, the synchronized bit is sampled at chosen instants. The filtered output moves to a new value only after a programmed number of consecutive samples all differ from the present output.

Sample instants come from one of two sources. The first is an internal divider that fires once every N clock cycles. The second is an external strobe, which is synchronized and acts on its rising edges. A zero period with the external source deselected switches the filter off and returns it to a known state. In that setting, and whenever the agreement count is 0 or 1, the output is just the synchronized raw bit. Rising and falling flags report each change of the output.

Top module: `cmpf_top`

## Requirements
- R1: While reset is asserted and right after it, `filt_o`, `rise_o` and `fall_o` are 0.
- R2: Filtering is active only when `count_i` is greater than 1 and either `period_i` is non-zero or `ext_en_i` is 1.
- R3: When filtering is not active, `filt_o` equals `raw_i` delayed by exactly two clock cycles.
- R4: With `ext_en_i`=0 and `period_i`=N (N≥2), the internal source samples once every N cycles. With the settings applied during reset and `raw_i` held at 1, `filt_o` first reads 1 after clock edge C·N+1 following reset release, where C is `count_i`.
- R5: With `ext_en_i`=1, samples are taken only at rising edges of the synchronized `strobe_i`, whatever `period_i` holds. With `raw_i` held at 1, `filt_o` rises on the C-th strobe pulse.
- R6: The filtered output changes only after C consecutive samples that differ from it. A sample equal to the output restarts the run from zero.
- R7: After reset the filtered output is 0, even while the raw input is 1, until enough samples agree.
- R8: `period_i`=0 together with `ext_en_i`=0 clears the agreement count and the filtered state. Filtering that is enabled again starts from output 0.
- R9: A change of `period_i` reloads the divider. In the cycle of the change no sample is taken, and the next sample follows the new period counted from the edge after the change.
- R10: `rise_o` and `fall_o` are one-cycle pulses. They are high in the first cycle in which `filt_o` shows the new value 1 or 0, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Unsynchronized comparator bit, already inverted if needed |
| strobe_i | input | 1 | External sample strobe, asynchronous |
| period_i | input | 8 | Internal sample period in clock cycles, 0 = no internal source |
| count_i | input | 3 | Consecutive samples needed for a change |
| ext_en_i | input | 1 | Select the external strobe as the sample source |
| filt_o | output | 1 | Filtered (or bypassed) synchronized comparator bit |
| rise_o | output | 1 | Pulse when `filt_o` goes from 0 to 1 |
| fall_o | output | 1 | Pulse when `filt_o` goes from 1 to 0 |

## Verification
Two functions can land on the same clock edge: a rewrite of the period register and an internal sample tick. The bench provokes this by changing the period from 4 to 3 in the very cycle in which the old divider would fire. It then checks that the reload wins. No sample is taken on that edge, the first samples follow on the new three-cycle grid, and the output rise is expected exactly at edge 11 rather than edge 9.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_INT = 2'd1,
    SRC_EXT = 2'd2
  } src_e;
endpackage

// File: rtl/cmpf_sync.sv
module cmpf_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cmpf_tick.sv
module cmpf_tick
  import cmpf_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  src_e             src_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             stb_s_i,
  output logic             smp_o
);
  logic [PER_W-1:0] div_q, per_q;
  logic             stb_d_q;
  logic             per_chg, div_hit;

  assign per_chg = (period_i != per_q);
  assign div_hit = (div_q == period_i - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      per_q   <= '0;
      stb_d_q <= 1'b0;
    end else begin
      per_q   <= period_i;
      stb_d_q <= stb_s_i;
      if (src_i != SRC_INT || per_chg || div_hit) div_q <= '0;
      else                                         div_q <= div_q + PER_W'(1);
    end
  end

  always_comb begin
    unique case (src_i)
      SRC_INT: smp_o = div_hit && !per_chg;
      SRC_EXT: smp_o = stb_s_i && !stb_d_q;
      default: smp_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmpf_core.sv
module cmpf_core #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             smp_i,
  input  logic             din_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             q_o
);
  logic [CNT_W-1:0] run_q;
  logic             q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      q_q   <= 1'b0;
    end else if (!en_i) begin
      run_q <= '0;
      q_q   <= 1'b0;
    end else if (smp_i) begin
      if (din_i == q_q) begin
        run_q <= '0;
      end else if (run_q == need_i - CNT_W'(1)) begin
        run_q <= '0;
        q_q   <= din_i;
      end else begin
        run_q <= run_q + CNT_W'(1);
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/cmpf_top.sv
module cmpf_top
  import cmpf_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             strobe_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ext_en_i,
  output logic             filt_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int SW = 2;

  logic [SW-1:0] sync_in, sync_out;
  logic          raw_s, stb_s;
  src_e          src;
  logic          off_w, active_w, smp_w, q_w, out_now, out_d_q;

  assign sync_in = {strobe_i, raw_i};

  cmpf_sync #(.W(SW)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_in),
    .q_o   (sync_out)
  );

  assign raw_s = sync_out[0];
  assign stb_s = sync_out[1];

  always_comb begin
    if (ext_en_i)            src = SRC_EXT;
    else if (period_i != '0) src = SRC_INT;
    else                     src = SRC_OFF;
  end

  assign off_w    = (src == SRC_OFF);
  assign active_w = !off_w && (count_i > CNT_W'(1));

  cmpf_tick #(.PER_W(PER_W)) i_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src),
    .period_i(period_i),
    .stb_s_i (stb_s),
    .smp_o   (smp_w)
  );

  cmpf_core #(.CNT_W(CNT_W)) i_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active_w),
    .smp_i (smp_w),
    .din_i (raw_s),
    .need_i(count_i),
    .q_o   (q_w)
  );

  assign out_now = active_w ? q_w : raw_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_d_q <= 1'b0;
    else         out_d_q <= out_now;
  end

  assign filt_o = out_now;
  assign rise_o = out_now && !out_d_q;
  assign fall_o = !out_now && out_d_q;
endmodule

// File: rtl/cmpf_chk.sv
module cmpf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic raw_i,
  input logic filt_o,
  input logic rise_o,
  input logic fall_o,
  input logic active_i,
  input logic off_i,
  input logic smp_i,
  input logic q_i
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 2'd3)   cyc_q <= cyc_q + 2'd1;
  end

  AST_BYPASS_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && !active_i) |-> (filt_o == $past(raw_i, 2))); // R3

  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o)); // R10

  AST_RISE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R10

  AST_FALL_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R10

  AST_HOLD_NO_SMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && $past(active_i) && !$past(smp_i)) |-> $stable(q_i)); // R6

  AST_OFF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> !q_i); // R8

  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!filt_o && !rise_o && !fall_o)); // R1
endmodule

bind cmpf_top cmpf_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .raw_i   (raw_i),
  .filt_o  (filt_o),
  .rise_o  (rise_o),
  .fall_o  (fall_o),
  .active_i(active_w),
  .off_i   (off_w),
  .smp_i   (smp_w),
  .q_i     (q_w)
);

// File: tb/test_cmpf_top.sv
`timescale 1ns/1ps
module test_cmpf_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       raw_i = 1'b0;
  logic       strobe_i = 1'b0;
  logic [7:0] period_i = '0;
  logic [2:0] count_i = '0;
  logic       ext_en_i = 1'b0;
  logic       filt_o, rise_o, fall_o;

  int errors = 0;
  int checks = 0;
  int rises = 0;
  int falls = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  cmpf_top i_cmpf_top (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw_i),
    .strobe_i(strobe_i),
    .period_i(period_i),
    .count_i (count_i),
    .ext_en_i(ext_en_i),
    .filt_o  (filt_o),
    .rise_o  (rise_o),
    .fall_o  (fall_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) begin
      @(negedge clk_i);
      if (rise_o) rises++;
      if (fall_o) falls++;
    end
  endtask

  task automatic pulse();
    strobe_i = 1'b1;
    wait_n(2);
    strobe_i = 1'b0;
    wait_n(3);
  endtask

  initial begin
    // R1: reset values
    raw_i = 1'b1; count_i = 3'd3; period_i = 8'd2;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 reset filt", filt_o, 0);
    check("R1 reset edges", rise_o | fall_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", filt_o | rise_o | fall_o, 0);

    // R4 R7 R10: internal timebase sweep
    for (int n = 2; n <= 5; n++) begin
      for (int c = 2; c <= 7; c++) begin
        int bad, rise_bad, fall_seen;
        bad = 0; rise_bad = 0; fall_seen = 0;
        raw_i = 1'b1; ext_en_i = 1'b0; period_i = 8'(n); count_i = 3'(c);
        do_reset();
        for (int k = 1; k <= c * n + 4; k++) begin
          @(negedge clk_i);
          if (filt_o != (k >= c * n + 1)) bad++;
          if (rise_o != (k == c * n + 1)) rise_bad++;
          if (fall_o) fall_seen++;
        end
        check($sformatf("R4 R7 output timing n=%0d c=%0d", n, c), bad, 0);
        check($sformatf("R10 rise pulse n=%0d c=%0d", n, c), rise_bad, 0);
        check("R10 no fall", fall_seen, 0);
      end
    end

    // R5: external strobe sweep, internal period ignored
    for (int c = 2; c <= 7; c++) begin
      raw_i = 1'b1; ext_en_i = 1'b1; period_i = 8'd3; count_i = 3'(c);
      do_reset();
      wait_n(40);
      check("R5 no sample without strobe", filt_o, 0);
      for (int p = 1; p < c; p++) pulse();
      check($sformatf("R5 before last strobe c=%0d", c), filt_o, 0);
      rises = 0;
      pulse();
      check($sformatf("R5 after strobe %0d", c), filt_o, 1);
      check("R10 one rise on strobe", rises, 1);
    end

    // R6: agreeing sample restarts the run (C=3, external)
    raw_i = 1'b1; ext_en_i = 1'b1; period_i = 8'd0; count_i = 3'd3;
    do_reset();
    wait_n(3);
    repeat (3) pulse();
    check("R6 set high", filt_o, 1);
    raw_i = 1'b0; wait_n(3);
    repeat (2) pulse();
    raw_i = 1'b1; wait_n(3);
    pulse();
    raw_i = 1'b0; wait_n(3);
    falls = 0;
    repeat (2) pulse();
    check("R6 run restarted, still high", filt_o, 1);
    check("R6 no fall yet", falls, 0);
    pulse();
    check("R6 third disagree flips", filt_o, 0);
    check("R10 one fall", falls, 1);

    // R2 R3: bypass when count<=1 or when off
    for (int m = 0; m < 2; m++) begin
      raw_i = 1'b0; strobe_i = 1'b0;
      ext_en_i = 1'b0;
      period_i = (m == 0) ? 8'd3 : 8'd0;
      count_i  = (m == 0) ? 3'd1 : 3'd5;
      do_reset();
      wait_n(3);
      raw_i = 1'b1;
      @(negedge clk_i);
      check("R3 one cycle later still low", filt_o, 0);
      @(negedge clk_i);
      check("R2 R3 bypass follows raw", filt_o, 1);
      check("R10 bypass rise", rise_o, 1);
      @(negedge clk_i);
      check("R10 rise single cycle", rise_o, 0);
      raw_i = 1'b0;
      repeat (2) @(negedge clk_i);
      check("R3 bypass fall", filt_o, 0);
      check("R10 bypass fall pulse", fall_o, 1);
    end

    // R8: off setting clears state, re-enable starts from 0
    raw_i = 1'b1;
    wait_n(3);
    check("R8 off follows raw", filt_o, 1);
    ext_en_i = 1'b1; count_i = 3'd3;
    #1;
    check("R8 re-enabled output cleared", filt_o, 0);
    repeat (2) pulse();
    check("R8 fresh run not done", filt_o, 0);
    pulse();
    check("R8 fresh run done", filt_o, 1);

    // R9: period change in the tick cycle reloads the divider
    raw_i = 1'b1; ext_en_i = 1'b0; period_i = 8'd4; count_i = 3'd2;
    do_reset();
    repeat (4) @(negedge clk_i);
    period_i = 8'd3;
    begin
      int bad9;
      bad9 = 0;
      for (int k = 5; k <= 13; k++) begin
        @(negedge clk_i);
        if (filt_o != (k >= 11)) bad9++;
      end
      check("R9 reload timing", bad9, 0);
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule